// File: doc/BRIEF.md
# CAN Fault Confinement Unit

This unit keeps the transmit and receive error counts of a CAN node and derives the node's fault confinement state from them. The protocol engine sends it single-cycle strobes: transmit error, receive error, successful transmission and successful reception. For every bit time it also sends a bit strobe carrying the received level and a flag that marks the acknowledge slot of the node's own frame. From these inputs the unit moves between three states: error active, error passive and bus off.

The outputs feed the rest of the controller. When an error is detected, the error frame generator receives a request, together with a select that picks a passive error flag instead of an active one. After a transmission in the passive state, the transmitter receives a suspend request. A bus-drive inhibit stays high for the whole bus-off period. Recovery from bus off is automatic once the bus has shown 128 runs of 11 consecutive recessive bits. It also happens on a controller init. A masked interrupt stays high for as long as an enabled state holds.

Top module: `can_fault_conf`

## Requirements
- R1: After reset or a cycle with `init_i` high, the state is error active and both counters are zero. Exactly one state flag is high at all times.
- R2: A transmit error adds 8 to TEC. A receive error adds 1 to REC, and REC saturates at 511 instead of wrapping.
- R3: A successful transmission or reception subtracts 1 from TEC or REC respectively, with a floor of zero. An error in the same cycle takes precedence over the success in that direction.
- R4: Error active moves to error passive when TEC or REC becomes greater than 127. A value of exactly 127 keeps the node active.
- R5: Error passive returns to error active only when TEC and REC are both below 127. A value of 127 in either counter keeps the node passive.
- R6: When TEC would exceed 255, the state becomes bus off, both counters are cleared and `drive_inhibit_o` is high. While the node is bus off, all error, success and acknowledge events are ignored and no error frame is requested.
- R7: Bus off ends on the bit that completes the 128th run of 11 consecutive recessive bits (`bit_val_i` = 1). A dominant bit restarts the current run without discarding the runs already completed.
- R8: A recessive level on a bit strobe with `ack_slot_i` high, outside bus off, raises `ack_err_o` and `err_frame_o` in the next cycle and counts as a transmit error (TEC + 8).
- R9: Every detected error outside bus off raises `err_frame_o` for one cycle. `err_passive_o` is high with it exactly when the state at detection time was error passive.
- R10: A successful transmission while error passive raises `suspend_o` for one cycle.
- R11: `irq_o` is high while the current state's mask bit is set, using `irq_mask_i[0]` for active, `[1]` for passive and `[2]` for bus off.
- R12: A cycle with `init_i` high returns a bus-off node to error active at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| init_i | input | 1 | Synchronous controller init |
| tx_err_i | input | 1 | Transmit error strobe |
| rx_err_i | input | 1 | Receive error strobe |
| tx_ok_i | input | 1 | Successful transmission strobe |
| rx_ok_i | input | 1 | Successful reception strobe |
| bit_valid_i | input | 1 | One strobe per bit time |
| bit_val_i | input | 1 | Sampled bus level, 1 = recessive |
| ack_slot_i | input | 1 | Current bit is the acknowledge slot of an own frame |
| irq_mask_i | input | 3 | Interrupt enables: [0] active, [1] passive, [2] bus off |
| tec_o | output | CNT_W | Transmit error count |
| rec_o | output | CNT_W | Receive error count |
| st_active_o | output | 1 | State is error active |
| st_passive_o | output | 1 | State is error passive |
| st_busoff_o | output | 1 | State is bus off |
| err_frame_o | output | 1 | Error frame request pulse |
| err_passive_o | output | 1 | Requested error frame uses the passive flag |
| ack_err_o | output | 1 | Acknowledge error pulse |
| suspend_o | output | 1 | Suspend-transmission request pulse |
| drive_inhibit_o | output | 1 | Node must not drive the bus |
| irq_o | output | 1 | Masked state interrupt |

## Verification
Counter and state registers update on the same edge as the strobe that changes them. A wrong increment, floor or saturation therefore appears on `tec_o`/`rec_o` one cycle after the event. A wrong threshold compare shows up as a state flag, and the interrupt that follows it, flipping one event early or late around 127 and 255. A fault in the recessive-run tracker is only visible at the end of bus off, where recovery comes one bit too early or too late after about 1400 bit strobes. For that reason the bench steps the bus-off sequence bit by bit and checks the flags on every bit.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;
  typedef enum logic [1:0] {
    FC_ACTIVE  = 2'd0,
    FC_PASSIVE = 2'd1,
    FC_BUSOFF  = 2'd2
  } fc_state_e;
endpackage

// File: rtl/fc_err_counters.sv
module fc_err_counters #(
  parameter int unsigned CNT_W  = 9,
  parameter int unsigned TX_INC = 8,
  parameter int unsigned RX_INC = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             hold_i,
  input  logic             tx_err_i,
  input  logic             rx_err_i,
  input  logic             tx_ok_i,
  input  logic             rx_ok_i,
  output logic [CNT_W-1:0] tec_nx_o,
  output logic [CNT_W-1:0] rec_nx_o,
  output logic [CNT_W-1:0] tec_o,
  output logic [CNT_W-1:0] rec_o
);
  localparam int unsigned NLANE = 2;

  logic [NLANE-1:0] up, dn;
  logic [CNT_W-1:0] cnt_q  [NLANE];
  logic [CNT_W-1:0] cnt_nx [NLANE];

  assign up = {rx_err_i, tx_err_i};
  assign dn = {rx_ok_i,  tx_ok_i};

  // lane 0 = transmit, lane 1 = receive
  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    localparam int unsigned INC = (g == 0) ? TX_INC : RX_INC;
    logic [CNT_W:0] sum;

    assign sum = {1'b0, cnt_q[g]} + (CNT_W+1)'(INC);

    always_comb begin
      if (hold_i)                        cnt_nx[g] = cnt_q[g];
      else if (up[g])                    cnt_nx[g] = sum[CNT_W] ? '1 : sum[CNT_W-1:0];
      else if (dn[g] && cnt_q[g] != '0)  cnt_nx[g] = cnt_q[g] - 1'b1;
      else                               cnt_nx[g] = cnt_q[g];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    cnt_q[g] <= '0;
      else if (clr_i) cnt_q[g] <= '0;
      else            cnt_q[g] <= cnt_nx[g];
    end
  end

  assign tec_nx_o = cnt_nx[0];
  assign rec_nx_o = cnt_nx[1];
  assign tec_o    = cnt_q[0];
  assign rec_o    = cnt_q[1];
endmodule

// File: rtl/fc_busoff_recovery.sv
module fc_busoff_recovery #(
  parameter int unsigned RUN_LEN = 11,
  parameter int unsigned RUN_NUM = 128
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic bit_valid_i,
  input  logic bit_rec_i,
  output logic done_o
);
  localparam int unsigned BW = (RUN_LEN > 1) ? $clog2(RUN_LEN) : 1;
  localparam int unsigned RW = (RUN_NUM > 1) ? $clog2(RUN_NUM) : 1;

  logic [BW-1:0] bit_q;
  logic [RW-1:0] run_q;
  logic          run_end;

  assign run_end = bit_valid_i & bit_rec_i & (bit_q == BW'(RUN_LEN - 1));
  assign done_o  = en_i & run_end & (run_q == RW'(RUN_NUM - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q <= '0;
      run_q <= '0;
    end else if (!en_i) begin
      bit_q <= '0;
      run_q <= '0;
    end else if (bit_valid_i) begin
      if (!bit_rec_i) begin
        bit_q <= '0;  // dominant bit restarts the current run only
      end else if (run_end) begin
        bit_q <= '0;
        run_q <= done_o ? '0 : run_q + 1'b1;
      end else begin
        bit_q <= bit_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fc_state_fsm.sv
module fc_state_fsm
  import can_fc_pkg::*;
#(
  parameter int unsigned CNT_W       = 9,
  parameter int unsigned PASSIVE_LIM = 127,
  parameter int unsigned BOFF_LIM    = 255
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_i,
  input  logic             recover_i,
  input  logic [CNT_W-1:0] tec_nx_i,
  input  logic [CNT_W-1:0] rec_nx_i,
  output fc_state_e        state_o,
  output logic             clr_o
);
  localparam logic [CNT_W-1:0] PLIM = CNT_W'(PASSIVE_LIM);
  localparam logic [CNT_W-1:0] BLIM = CNT_W'(BOFF_LIM);

  fc_state_e st_q, st_d;
  logic      to_boff;

  assign to_boff = (st_q != FC_BUSOFF) && (tec_nx_i > BLIM);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      FC_ACTIVE: begin
        if (to_boff)                                st_d = FC_BUSOFF;
        else if (tec_nx_i > PLIM || rec_nx_i > PLIM) st_d = FC_PASSIVE;
      end
      FC_PASSIVE: begin
        if (to_boff)                                st_d = FC_BUSOFF;
        else if (tec_nx_i < PLIM && rec_nx_i < PLIM) st_d = FC_ACTIVE;
      end
      FC_BUSOFF: if (recover_i) st_d = FC_ACTIVE;
      default:   st_d = FC_ACTIVE;
    endcase
    if (init_i) st_d = FC_ACTIVE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= FC_ACTIVE;
    else         st_q <= st_d;
  end

  assign state_o = st_q;
  assign clr_o   = init_i | to_boff;
endmodule

// File: rtl/can_fault_conf.sv
module can_fault_conf
  import can_fc_pkg::*;
#(
  parameter int unsigned CNT_W       = 9,
  parameter int unsigned TX_INC      = 8,
  parameter int unsigned RX_INC      = 1,
  parameter int unsigned PASSIVE_LIM = 127,
  parameter int unsigned BOFF_LIM    = 255,
  parameter int unsigned RUN_LEN     = 11,
  parameter int unsigned RUN_NUM     = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_i,
  input  logic             tx_err_i,
  input  logic             rx_err_i,
  input  logic             tx_ok_i,
  input  logic             rx_ok_i,
  input  logic             bit_valid_i,
  input  logic             bit_val_i,
  input  logic             ack_slot_i,
  input  logic [2:0]       irq_mask_i,
  output logic [CNT_W-1:0] tec_o,
  output logic [CNT_W-1:0] rec_o,
  output logic             st_active_o,
  output logic             st_passive_o,
  output logic             st_busoff_o,
  output logic             err_frame_o,
  output logic             err_passive_o,
  output logic             ack_err_o,
  output logic             suspend_o,
  output logic             drive_inhibit_o,
  output logic             irq_o
);
  fc_state_e        state;
  logic             busoff, passive, live;
  logic             ack_det, tx_err_eff, any_err;
  logic             clr, recover;
  logic [CNT_W-1:0] tec_nx, rec_nx;

  assign busoff     = (state == FC_BUSOFF);
  assign passive    = (state == FC_PASSIVE);
  assign live       = ~busoff & ~init_i;
  assign ack_det    = live & bit_valid_i & ack_slot_i & bit_val_i;
  assign tx_err_eff = tx_err_i | ack_det;
  assign any_err    = live & (tx_err_i | rx_err_i | ack_det);

  fc_err_counters #(
    .CNT_W (CNT_W),
    .TX_INC(TX_INC),
    .RX_INC(RX_INC)
  ) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .hold_i  (busoff),
    .tx_err_i(tx_err_eff),
    .rx_err_i(rx_err_i),
    .tx_ok_i (tx_ok_i),
    .rx_ok_i (rx_ok_i),
    .tec_nx_o(tec_nx),
    .rec_nx_o(rec_nx),
    .tec_o   (tec_o),
    .rec_o   (rec_o)
  );

  fc_state_fsm #(
    .CNT_W      (CNT_W),
    .PASSIVE_LIM(PASSIVE_LIM),
    .BOFF_LIM   (BOFF_LIM)
  ) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .init_i   (init_i),
    .recover_i(recover),
    .tec_nx_i (tec_nx),
    .rec_nx_i (rec_nx),
    .state_o  (state),
    .clr_o    (clr)
  );

  fc_busoff_recovery #(
    .RUN_LEN(RUN_LEN),
    .RUN_NUM(RUN_NUM)
  ) u_rcv (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (busoff),
    .bit_valid_i(bit_valid_i),
    .bit_rec_i  (bit_val_i),
    .done_o     (recover)
  );

  // flag type follows the state at detection time
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_frame_o   <= 1'b0;
      err_passive_o <= 1'b0;
      ack_err_o     <= 1'b0;
      suspend_o     <= 1'b0;
    end else begin
      err_frame_o   <= any_err;
      err_passive_o <= any_err & passive;
      ack_err_o     <= ack_det;
      suspend_o     <= live & tx_ok_i & passive;
    end
  end

  assign st_active_o     = (state == FC_ACTIVE);
  assign st_passive_o    = passive;
  assign st_busoff_o     = busoff;
  assign drive_inhibit_o = busoff;
  assign irq_o           = |({busoff, passive, st_active_o} & irq_mask_i);
endmodule

// File: rtl/can_fault_conf_chk.sv
module can_fault_conf_chk #(
  parameter int unsigned CNT_W       = 9,
  parameter int unsigned PASSIVE_LIM = 127
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             init_i,
  input logic             tx_err_i,
  input logic             tx_ok_i,
  input logic             bit_valid_i,
  input logic             bit_val_i,
  input logic             ack_slot_i,
  input logic [2:0]       irq_mask_i,
  input logic [CNT_W-1:0] tec_o,
  input logic [CNT_W-1:0] rec_o,
  input logic             st_active_o,
  input logic             st_passive_o,
  input logic             st_busoff_o,
  input logic             err_frame_o,
  input logic             ack_err_o,
  input logic             suspend_o,
  input logic             drive_inhibit_o,
  input logic             irq_o
);
  localparam logic [CNT_W-1:0] PLIM = CNT_W'(PASSIVE_LIM);

  a_r1_state_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot({st_active_o, st_passive_o, st_busoff_o}));

  a_r2_tx_add: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_err_i && !init_i && st_active_o && tec_o < CNT_W'(100))
    |=> tec_o == $past(tec_o) + CNT_W'(8));

  a_r4_over_limit_passive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tec_o > PLIM || rec_o > PLIM) |-> st_passive_o);

  a_r5_return_below: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(st_active_o) && $past(st_passive_o)) |-> (tec_o < PLIM && rec_o < PLIM));

  a_r6_busoff_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_busoff_o |-> (tec_o == '0 && rec_o == '0 && drive_inhibit_o));

  a_r8_ack_error: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_valid_i && ack_slot_i && bit_val_i && !st_busoff_o && !init_i)
    |=> (ack_err_o && err_frame_o));

  a_r10_suspend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_ok_i && st_passive_o && !init_i) |=> suspend_o);

  a_r11_busoff_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_busoff_o && irq_mask_i[2]) |-> irq_o);
endmodule

bind can_fault_conf can_fault_conf_chk #(
  .CNT_W      (CNT_W),
  .PASSIVE_LIM(PASSIVE_LIM)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .init_i         (init_i),
  .tx_err_i       (tx_err_i),
  .tx_ok_i        (tx_ok_i),
  .bit_valid_i    (bit_valid_i),
  .bit_val_i      (bit_val_i),
  .ack_slot_i     (ack_slot_i),
  .irq_mask_i     (irq_mask_i),
  .tec_o          (tec_o),
  .rec_o          (rec_o),
  .st_active_o    (st_active_o),
  .st_passive_o   (st_passive_o),
  .st_busoff_o    (st_busoff_o),
  .err_frame_o    (err_frame_o),
  .ack_err_o      (ack_err_o),
  .suspend_o      (suspend_o),
  .drive_inhibit_o(drive_inhibit_o),
  .irq_o          (irq_o)
);

// File: tb/test_can_fault_conf.sv
module test_can_fault_conf;
  localparam int CNT_W = 9;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic init_i = 0, tx_err_i = 0, rx_err_i = 0, tx_ok_i = 0, rx_ok_i = 0;
  logic bit_valid_i = 0, bit_val_i = 0, ack_slot_i = 0;
  logic [2:0] irq_mask_i = 3'b000;
  logic [CNT_W-1:0] tec_o, rec_o;
  logic st_active_o, st_passive_o, st_busoff_o;
  logic err_frame_o, err_passive_o, ack_err_o, suspend_o, drive_inhibit_o, irq_o;

  int n_run = 0, n_fail = 0;
  // model state: 0 active, 1 passive, 2 bus off
  int m_tec = 0, m_rec = 0, m_st = 0, m_bc = 0, m_rc = 0;
  bit e_frame = 0, e_pas = 0, e_ack = 0, e_susp = 0;

  always #10 clk_i = ~clk_i;

  can_fault_conf i_can_fault_conf (.*);

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic compare(input string req);
    chk(req, "tec", int'(tec_o), m_tec);
    chk(req, "rec", int'(rec_o), m_rec);
    chk(req, "state{boff,pas,act}", int'({st_busoff_o, st_passive_o, st_active_o}), 1 << m_st);
    chk(req, "inhibit", int'(drive_inhibit_o), int'(m_st == 2));
    chk(req, "pulses{frame,pas,ack,susp}",
        int'({err_frame_o, err_passive_o, ack_err_o, suspend_o}),
        int'({e_frame, e_pas, e_ack, e_susp}));
    chk(req, "irq", int'(irq_o), int'(irq_mask_i[m_st]));
  endtask

  task automatic step(input string req, input bit txe, input bit rxe, input bit txo,
                      input bit rxo, input bit bv, input bit bval, input bit ack, input bit ini);
    bit live, ackd, te;
    int tn, rn;
    tx_err_i = txe; rx_err_i = rxe; tx_ok_i = txo; rx_ok_i = rxo;
    bit_valid_i = bv; bit_val_i = bval; ack_slot_i = ack; init_i = ini;
    @(posedge clk_i);
    live    = !ini && m_st != 2;
    ackd    = live && bv && ack && bval;
    te      = txe || ackd;
    e_frame = live && (txe || rxe || ackd);
    e_pas   = e_frame && m_st == 1;
    e_ack   = ackd;
    e_susp  = live && txo && m_st == 1;
    if (ini) begin
      m_tec = 0; m_rec = 0; m_st = 0; m_bc = 0; m_rc = 0;
    end else if (m_st == 2) begin
      if (bv) begin
        if (bval) begin
          m_bc++;
          if (m_bc == 11) begin
            m_bc = 0; m_rc++;
            if (m_rc == 128) begin m_rc = 0; m_st = 0; end
          end
        end else m_bc = 0;
      end
    end else begin
      tn = te ? m_tec + 8 : ((txo && m_tec > 0) ? m_tec - 1 : m_tec);
      rn = rxe ? ((m_rec == 511) ? 511 : m_rec + 1) : ((rxo && m_rec > 0) ? m_rec - 1 : m_rec);
      if (tn > 255) begin
        m_st = 2; m_tec = 0; m_rec = 0; m_bc = 0; m_rc = 0;
      end else begin
        m_tec = tn; m_rec = rn;
        if (m_st == 0 && (m_tec > 127 || m_rec > 127)) m_st = 1;
        else if (m_st == 1 && m_tec < 127 && m_rec < 127) m_st = 0;
      end
    end
    @(negedge clk_i);
    tx_err_i = 0; rx_err_i = 0; tx_ok_i = 0; rx_ok_i = 0;
    bit_valid_i = 0; bit_val_i = 0; ack_slot_i = 0; init_i = 0;
    compare(req);
  endtask

  task automatic idle(input string req);      step(req, 0,0,0,0, 0,0,0, 0); endtask
  task automatic tx_err(input string req);    step(req, 1,0,0,0, 0,0,0, 0); endtask
  task automatic rx_err(input string req);    step(req, 0,1,0,0, 0,0,0, 0); endtask
  task automatic tx_ok(input string req);     step(req, 0,0,1,0, 0,0,0, 0); endtask
  task automatic rx_ok(input string req);     step(req, 0,0,0,1, 0,0,0, 0); endtask
  task automatic bus_bit(input string req, input bit v); step(req, 0,0,0,0, 1,v,0, 0); endtask
  task automatic do_init(input string req);   step(req, 0,0,0,0, 0,0,0, 1); endtask

  task automatic mask_sweep(input string req);
    for (int m = 0; m < 8; m++) begin
      irq_mask_i = 3'(m);
      idle(req);
    end
    irq_mask_i = 3'b000;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    compare("R1");
    mask_sweep("R11");

    // receive direction: floor, climb, saturation, hysteresis
    for (int i = 0; i < 5; i++) rx_err("R2");
    for (int i = 0; i < 6; i++) rx_ok("R3");
    for (int i = 0; i < 513; i++) rx_err(i < 128 ? "R4" : "R2");
    mask_sweep("R11");
    for (int i = 0; i < 385; i++) rx_ok("R5");  // down to 126, passes 127
    chk("R5", "back to active at 126", int'(st_active_o), 1);

    // transmit direction
    step("R3", 1,0,1,0, 0,0,0, 0);  // error beats success
    for (int i = 0; i < 14; i++) tx_err("R2");
    tx_err("R4");                    // 128
    tx_ok("R10");                    // 127, suspend, stays passive
    tx_ok("R5");                     // 126, active
    tx_err("R9");                    // active flag, 134 passive
    tx_err("R9");                    // passive flag
    rx_err("R9");

    // acknowledge slot
    step("R8", 0,0,0,0, 1,0,1, 0);   // dominant ack: fine
    step("R8", 0,0,0,0, 1,1,1, 0);   // recessive ack: error
    step("R8", 0,0,0,0, 1,1,0, 0);   // recessive, not ack slot
    for (int i = 0; i < 20 && m_st != 2; i++) tx_err("R6");
    chk("R6", "entered bus off", int'(st_busoff_o), 1);
    tx_err("R6"); rx_err("R6"); tx_ok("R6"); rx_ok("R6");
    step("R6", 0,0,0,0, 1,1,1, 0);   // ack ignored, also first recessive bit
    mask_sweep("R11");

    // recovery: partial run killed by a dominant bit
    for (int i = 0; i < 9; i++) bus_bit("R7", 1);
    bus_bit("R7", 0);
    for (int i = 0; i < 127 * 11; i++) bus_bit("R7", 1);
    for (int i = 0; i < 10; i++) bus_bit("R7", 1);
    chk("R7", "still bus off before last bit", int'(st_busoff_o), 1);
    bus_bit("R7", 1);
    chk("R7", "recovered", int'(st_active_o), 1);

    // init: from active with counts, then from bus off
    for (int i = 0; i < 3; i++) rx_err("R1");
    tx_err("R1");
    do_init("R1");
    for (int i = 0; i < 32 && m_st != 2; i++) tx_err("R6");
    do_init("R12");
    chk("R12", "active after init", int'(st_active_o), 1);
    idle("R12");
    finish_run();
  end
endmodule